// File: doc/BRIEF.md
# Prescaled SDRAM Refresh Request Timer

This block tells an SDRAM command sequencer when to issue auto-refresh commands. The bus clock passes through a prescaler whose ratio comes from an encoded 3-bit clock-select field. An interval counter advances on each prescaled tick. When it reaches a programmed constant it returns to zero and a compare match occurs. Each match adds a configurable number of refreshes to a pending count, one to eight. The sequencer sees a level request while that count is nonzero and acknowledges each refresh it performs.

Two configuration registers are written through one write port. One holds the control fields and the other holds the interval constant. A write is accepted only when its upper half-word carries a fixed key, so a stray store cannot change the refresh timing. Refresh runs only while the enable bit is set and the mode bit selects auto refresh. In any other setting the timer is parked at zero.

Top module: `sdram_refresh_timer`

## Requirements
- R1: A configuration write changes a register only when `cfg_wdata[31:16]` equals 16'hA55A. Any other key leaves both registers unchanged. `cfg_sel`=0 addresses the control register and `cfg_sel`=1 addresses the constant register, whose value is taken from `cfg_wdata[CNT_W-1:0]`.
- R2: The control register takes `cfg_wdata[7:0]` and reads back on `ctrl_rd`. Its fields are: clock-select in bits 2:0, repeat field in bits 5:3, enable in bit 6, and mode in bit 7 (0 means auto refresh).
- R3: The prescaler ratio depends on the clock-select value. Value 0 produces no ticks. A value n from 1 to 6 divides the bus clock by 4^n, so 3'b010 gives /16. Value 7 divides by 4096.
- R4: `timer_cnt` advances by one on every tick. On the tick that would make it equal to the constant, it clears to zero and a match occurs. A match therefore occurs every constant ticks: a constant of 39 with /16 gives one match every 624 bus clocks.
- R5: Each match adds (repeat field + 1) to `pending_cnt`, so a repeat field of 3'b000 asks for one refresh.
- R6: `pending_cnt` handles acknowledges and limits as follows.
  - An acknowledge while `pending_cnt` is nonzero takes one away.
  - An acknowledge at zero is ignored.
  - A match and an acknowledge in the same cycle both apply.
  - The count saturates at 2^PEND_W-1.
- R7: `refresh_req` is high exactly while `pending_cnt` is nonzero. The interval counter keeps counting while refreshes are pending.
- R8: While the enable bit is 0 or the mode bit is 1, the prescaler, `timer_cnt` and `pending_cnt` are held at zero and `refresh_req` is low.
- R9: After reset both registers, `timer_cnt` and `pending_cnt` are zero and `refresh_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Register select: 0 control, 1 constant |
| cfg_wdata | input | 32 | Write data; key in bits 31:16 |
| refresh_ack | input | 1 | Sequencer has issued one refresh |
| refresh_req | output | 1 | Refreshes are pending |
| pending_cnt | output | PEND_W | Number of outstanding refreshes |
| timer_cnt | output | CNT_W | Interval counter value |
| ctrl_rd | output | 8 | Control register contents |
| const_rd | output | CNT_W | Constant register contents |

## Verification
The bench measures the spacing between requests at /16 with a constant of 39. An off-by-one compare would show up as 640 or 608 cycles instead of 624. It lets a burst of repeated matches run without acknowledges until the pending count saturates; a design without the clamp would wrap to a small value and drop refreshes. It also writes with a wrong key, acknowledges at zero, and disables the timer while refreshes are pending. A faulty design would take the bad write, underflow to all ones, or keep requesting after disable. A randomized phase with a cycle model then covers simultaneous match and acknowledge and clock-select changes in mid-interval.

// File: rtl/srt_pkg.sv
package srt_pkg;
   localparam logic [15:0] WR_KEY = 16'hA55A;
   localparam int CTRL_W = 8;

   typedef struct packed {
      logic       self_mode;
      logic       enable;
      logic [2:0] repeat_m1;
      logic [2:0] clk_sel;
   } ctrl_t;
endpackage

// File: rtl/srt_regs.sv
module srt_regs
   import srt_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             sel,
   input  logic [31:0]      wdata,
   output ctrl_t            ctrl,
   output logic [CNT_W-1:0] tconst
);
   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt_w
      $error("srt_regs: CNT_W must be within 2..16");
   end

   logic key_ok;
   assign key_ok = (wdata[31:16] == WR_KEY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl   <= '0;
         tconst <= '0;
      end else if (wr && key_ok) begin
         if (sel) tconst <= wdata[CNT_W-1:0];
         else     ctrl   <= ctrl_t'(wdata[CTRL_W-1:0]);
      end
   end

   // R1
   bad_key_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !key_ok) |=> ($stable(ctrl) && $stable(tconst)));
endmodule

// File: rtl/srt_prescaler.sv
module srt_prescaler #(
   parameter int PRE_W     = 12,
   parameter bit TICK_FLOP = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       active,
   input  logic [2:0] clk_sel,
   output logic       tick
);
   if (PRE_W < 12) begin : g_bad_pre_w
      $error("srt_prescaler: PRE_W must be at least 12");
   end

   logic [PRE_W-1:0] pre;
   logic [PRE_W-1:0] mask;
   logic [3:0]       shamt;
   logic             raw_tick;

   always_comb begin
      shamt    = (clk_sel == 3'd7) ? 4'd12 : {clk_sel, 1'b0};
      mask     = (PRE_W'(1) << shamt) - PRE_W'(1);
      raw_tick = active && (clk_sel != 3'd0) && ((pre & mask) == mask);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pre <= '0;
      else if (!active) pre <= '0;
      else              pre <= pre + PRE_W'(1);
   end

   if (TICK_FLOP) begin : g_flop_tick
      logic tick_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) tick_q <= 1'b0;
         else        tick_q <= raw_tick;
      end
      assign tick = tick_q && active;
   end else begin : g_comb_tick
      assign tick = raw_tick;
   end

   // R8
   idle_prescaler_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (pre == '0));
   // R3
   no_back_to_back_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (!tick || !$stable(clk_sel)));
endmodule

// File: rtl/srt_interval.sv
module srt_interval #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             tick,
   input  logic [CNT_W-1:0] tconst,
   output logic [CNT_W-1:0] cnt,
   output logic             match
);
   logic [CNT_W-1:0] cnt_inc;

   assign cnt_inc = cnt + CNT_W'(1);
   assign match   = tick && (cnt_inc == tconst);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (!active) cnt <= '0;
      else if (match)   cnt <= '0;
      else if (tick)    cnt <= cnt_inc;
   end

   // R4
   clear_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match |=> (cnt == '0));
   // R4
   hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !tick) |=> $stable(cnt));
endmodule

// File: rtl/srt_pending.sv
module srt_pending #(
   parameter int PEND_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              match,
   input  logic [2:0]        repeat_m1,
   input  logic              ack,
   output logic [PEND_W-1:0] pend
);
   if (PEND_W < 4 || PEND_W > 16) begin : g_bad_pend_w
      $error("srt_pending: PEND_W must be within 4..16");
   end

   localparam int SUM_W = PEND_W + 2;
   localparam logic [SUM_W-1:0] PMAX = SUM_W'((1 << PEND_W) - 1);

   logic [SUM_W-1:0] add_amt;
   logic [SUM_W-1:0] sum;
   logic             take;

   always_comb begin
      add_amt = match ? (SUM_W'(repeat_m1) + SUM_W'(1)) : '0;
      take    = ack && (pend != '0);
      sum     = SUM_W'(pend) + add_amt - SUM_W'(take);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pend <= '0;
      else if (!active)   pend <= '0;
      else if (sum > PMAX) pend <= PMAX[PEND_W-1:0];
      else                pend <= sum[PEND_W-1:0];
   end

   // R8
   idle_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (pend == '0));
   // R6
   ack_decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && ack && (pend != '0) && !match) |=> (pend == $past(pend) - PEND_W'(1)));
   // R6
   ack_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && (pend == '0) && !match) |=> (pend == '0));
endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer
   import srt_pkg::*;
#(
   parameter int CNT_W     = 8,
   parameter int PEND_W    = 6,
   parameter int PRE_W     = 12,
   parameter bit TICK_FLOP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic              cfg_sel,
   input  logic [31:0]       cfg_wdata,
   input  logic              refresh_ack,
   output logic              refresh_req,
   output logic [PEND_W-1:0] pending_cnt,
   output logic [CNT_W-1:0]  timer_cnt,
   output logic [7:0]        ctrl_rd,
   output logic [CNT_W-1:0]  const_rd
);
   ctrl_t            ctrl;
   logic [CNT_W-1:0] tconst;
   logic             active;
   logic             tick;
   logic             match;

   srt_regs #(.CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel),
      .wdata(cfg_wdata), .ctrl(ctrl), .tconst(tconst)
   );

   assign active = ctrl.enable && !ctrl.self_mode;

   srt_prescaler #(.PRE_W(PRE_W), .TICK_FLOP(TICK_FLOP)) u_pre (
      .clk(clk), .rst_n(rst_n), .active(active),
      .clk_sel(ctrl.clk_sel), .tick(tick)
   );

   srt_interval #(.CNT_W(CNT_W)) u_int (
      .clk(clk), .rst_n(rst_n), .active(active), .tick(tick),
      .tconst(tconst), .cnt(timer_cnt), .match(match)
   );

   srt_pending #(.PEND_W(PEND_W)) u_pend (
      .clk(clk), .rst_n(rst_n), .active(active), .match(match),
      .repeat_m1(ctrl.repeat_m1), .ack(refresh_ack), .pend(pending_cnt)
   );

   assign refresh_req = (pending_cnt != '0);
   assign ctrl_rd     = ctrl;
   assign const_rd    = tconst;

   // R7
   req_follows_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (refresh_req && !refresh_ack && active) |=> (refresh_req || !active));
endmodule

// File: tb/tb_sdram_refresh_timer.sv
`timescale 1ns/1ps
module tb_sdram_refresh_timer;
   localparam int CNT_W  = 8;
   localparam int PEND_W = 6;
   localparam int PRE_W  = 12;
   localparam int CMASK  = (1 << CNT_W) - 1;
   localparam int PMAXV  = (1 << PEND_W) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_wr = 1'b0;
   logic              cfg_sel = 1'b0;
   logic [31:0]       cfg_wdata = '0;
   logic              refresh_ack = 1'b0;
   logic              refresh_req;
   logic [PEND_W-1:0] pending_cnt;
   logic [CNT_W-1:0]  timer_cnt;
   logic [7:0]        ctrl_rd;
   logic [CNT_W-1:0]  const_rd;

   sdram_refresh_timer #(.CNT_W(CNT_W), .PEND_W(PEND_W), .PRE_W(PRE_W)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .refresh_ack(refresh_ack),
      .refresh_req(refresh_req), .pending_cnt(pending_cnt),
      .timer_cnt(timer_cnt), .ctrl_rd(ctrl_rd), .const_rd(const_rd)
   );

   always #2.5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   int ack_mode = 0;
   int cyc = 0;

   int m_ctrl = 0, m_const = 0, m_pre = 0, m_cnt = 0, m_pend = 0;
   bit prev_req = 1'b0;
   int rise_cyc[$];

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
      end
   endtask

   function automatic int div_of(input int cks);
      if (cks == 0) return 0;
      if (cks == 7) return 4096;
      return 1 << (2 * cks);
   endfunction

   task automatic model_update();
      bit act, tk, mt;
      int dv, nc, inc, dec, np;
      act = m_ctrl[6] && !m_ctrl[7];
      dv  = div_of(m_ctrl & 7);
      tk  = act && (dv != 0) && ((m_pre % dv) == dv - 1);
      nc  = (m_cnt + 1) & CMASK;
      mt  = tk && (nc == m_const);
      inc = mt ? (((m_ctrl >> 3) & 7) + 1) : 0;
      dec = (refresh_ack && m_pend != 0) ? 1 : 0;
      np  = m_pend + inc - dec;
      if (np > PMAXV) np = PMAXV;
      m_pend = act ? np : 0;
      m_cnt  = !act ? 0 : mt ? 0 : tk ? nc : m_cnt;
      m_pre  = act ? ((m_pre + 1) % (1 << PRE_W)) : 0;
      if (cfg_wr && cfg_wdata[31:16] == 16'hA55A) begin
         if (cfg_sel) m_const = cfg_wdata & CMASK;
         else         m_ctrl  = cfg_wdata[7:0];
      end
   endtask

   task automatic compare();
      check(ctrl_rd == m_ctrl[7:0], "R2 ctrl", ctrl_rd, m_ctrl);
      check(const_rd == m_const[CNT_W-1:0], "R1 const", const_rd, m_const);
      check(timer_cnt == m_cnt[CNT_W-1:0], "R4 timer", timer_cnt, m_cnt);
      check(pending_cnt == m_pend[PEND_W-1:0], "R6 pending", pending_cnt, m_pend);
      check(refresh_req == (m_pend != 0), "R7 req", refresh_req, m_pend != 0);
      if (refresh_req && !prev_req) rise_cyc.push_back(cyc);
      prev_req = refresh_req;
   endtask

   task automatic step();
      @(posedge clk);
      model_update();
      @(negedge clk);
      compare();
      cyc++;
      cfg_wr = 1'b0;
      case (ack_mode)
         1: refresh_ack = refresh_req;
         2: refresh_ack = ($urandom % 3) == 0;
         default: refresh_ack = 1'b0;
      endcase
   endtask

   task automatic write_reg(input bit sel, input logic [31:0] data);
      cfg_sel = sel; cfg_wdata = data; cfg_wr = 1'b1;
      step();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R9 reset state
      check(refresh_req == 1'b0 && pending_cnt == 0 && timer_cnt == 0, "R9 reset outputs",
            {refresh_req, pending_cnt, timer_cnt}, 0);
      check(ctrl_rd == 0 && const_rd == 0, "R9 reset regs", {ctrl_rd, const_rd}, 0);
      rst_n = 1'b1;
      step();

      // R1 wrong key is ignored
      write_reg(1'b0, 32'hA55B_0052);
      step();
      check(ctrl_rd == 8'h00, "R1 bad key ctrl", ctrl_rd, 0);
      write_reg(1'b1, 32'h0000_0027);
      step();
      check(const_rd == 0, "R1 bad key const", const_rd, 0);

      // R4 R3 R5: /16, constant 39, one refresh per match
      write_reg(1'b1, 32'hA55A_0027);
      ack_mode = 1;
      write_reg(1'b0, 32'hA55A_0042);
      rise_cyc.delete();
      repeat (2200) step();
      check(rise_cyc.size() >= 3, "R4 request count", rise_cyc.size(), 3);
      if (rise_cyc.size() >= 3)
         check(rise_cyc[2] - rise_cyc[1] == 624, "R4 interval 39 x16",
               rise_cyc[2] - rise_cyc[1], 624);

      // R5 repeat of four per match, no acknowledges
      ack_mode = 0;
      write_reg(1'b0, 32'hA55A_0000);
      write_reg(1'b1, 32'hA55A_0005);
      write_reg(1'b0, 32'hA55A_0059);
      for (int i = 0; i < 100 && !refresh_req; i++) step();
      check(pending_cnt == 4, "R5 repeat of four", pending_cnt, 4);
      // R7 counter keeps running while pending
      repeat (8) step();
      check(refresh_req == 1'b1 && timer_cnt != 0, "R7 counting while pending",
            timer_cnt, 1);
      // R6 saturation
      repeat (400) step();
      check(pending_cnt == PMAXV, "R6 saturation", pending_cnt, PMAXV);

      // R8 disable clears everything
      write_reg(1'b0, 32'hA55A_0019);
      step();
      check(pending_cnt == 0 && timer_cnt == 0 && !refresh_req, "R8 disabled",
            pending_cnt, 0);
      // R8 self mode also parks the timer
      write_reg(1'b0, 32'hA55A_00D9);
      repeat (50) step();
      check(pending_cnt == 0 && timer_cnt == 0, "R8 mode bit", timer_cnt, 0);

      // R6 acknowledge at zero is ignored
      ack_mode = 0;
      refresh_ack = 1'b1;
      step();
      check(pending_cnt == 0, "R6 ack at zero", pending_cnt, 0);

      // random phase, all requirements against the model
      ack_mode = 2;
      write_reg(1'b0, 32'hA55A_0049);
      for (int i = 0; i < 40000; i++) begin
         if (($urandom % 60) == 0) begin
            logic [31:0] d;
            d = $urandom;
            if (($urandom % 4) != 0) d[31:16] = 16'hA55A;
            if (($urandom % 4) != 0) begin
               d[7] = 1'b0;
               d[6] = 1'b1;
            end
            if (($urandom % 3) != 0 && d[2:0] > 3'd3) d[2:0] = 3'd1;
            cfg_sel = $urandom % 2;
            cfg_wdata = d;
            cfg_wr = 1'b1;
         end
         step();
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule